// File: doc/BRIEF.md
# Extended-Precision Float Compare Unit

This unit compares two 80-bit double-extended floating-point values, one from the top of a register stack (slot 0) and one from a slot addressed relative to the top (slot i). It returns an ordering as three integer condition flags (zero, parity, carry) and reports two exceptions: invalid operand and stack underflow. A mode input selects between a signaling compare, where every NaN is an error, and a quiet compare, where only signaling NaNs and malformed encodings are errors.

The caller presents the current stack top pointer and the per-slot occupancy bits with each request. The unit returns their next values, and these reflect an optional pop after the compare. A mask input chooses what an exception does to the flags. When the mask is set, the flags take the unordered code. When it is clear, the flags keep their old values and the pop is suppressed. Results are registered and appear one cycle after the request.

Operand layout: sign at bit 79, a 15-bit biased exponent at bits 78:64, an explicit integer bit at bit 63 and the fraction at bits 62:0. An occupancy bit of 1 means the slot holds a value, and 0 means it is empty.

Top module: `xfp_compare_unit`

## Requirements
- R1: For ordered operands the flags {zf,pf,cf} are 000 when slot 0 is greater, 001 when it is less and 100 when the two are equal. No other ordered code appears, so pf always equals zf AND cf.
- R2: When an operand is a NaN (all-ones exponent, integer bit 1, nonzero fraction) and no exception is raised, the flags read 111.
- R3: Positive and negative zero compare as equal.
- R4: In signaling mode (signal_mode_i=1), any NaN (quiet: fraction bit 62 = 1; signaling: bit 62 = 0) or any unsupported encoding raises inv_exc_o.
- R5: In quiet mode, a quiet NaN raises no exception. inv_exc_o is raised only for a signaling NaN or an unsupported encoding (nonzero exponent with integer bit 0).
- R6: When an exception is raised and inv_mask_i=1, the flags become 111. When inv_mask_i=0, the flags keep their previous values.
- R7: After every compare, of_o, sf_o, af_o and c1_o read 0.
- R8: With pop_req_i=1 and no unmasked exception, the occupancy bit of the slot at the old top is cleared and top_o = top_i + 1 modulo 8. Otherwise top_o and tag_valid_o equal the presented values.
- R9: If slot 0 (physical index top_i) or slot i (physical index top_i + slot_idx_i modulo 8) is empty, stk_exc_o is raised instead of inv_exc_o, and the flags follow the R6 mask rule.
- R10: Magnitude ordering covers every class. Infinity exceeds the largest finite value. A denormal is below the smallest normal. A pseudo-denormal (exponent 0, integer bit 1) equals the normal with exponent 1 and the same significand.
- R11: done_o is high exactly one cycle after each request, and its results appear in that same cycle. Without a request the flags, top_o and tag_valid_o hold, and both exceptions read 0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_valid_i | input | 1 | Compare request |
| signal_mode_i | input | 1 | 1 = signaling compare, 0 = quiet compare |
| pop_req_i | input | 1 | Pop the stack after the compare |
| inv_mask_i | input | 1 | Exception mask; 1 = write unordered flags on exception |
| src0_i | input | 80 | Operand from slot 0 |
| srci_i | input | 80 | Operand from slot i |
| slot_idx_i | input | 3 | Index i relative to the top |
| top_i | input | 3 | Current stack top pointer |
| tag_valid_i | input | 8 | Per-slot occupancy, indexed physically |
| done_o | output | 1 | Result valid |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag, cleared |
| sf_o | output | 1 | Sign flag, cleared |
| af_o | output | 1 | Auxiliary-carry flag, cleared |
| c1_o | output | 1 | Condition bit C1, cleared |
| inv_exc_o | output | 1 | Invalid-operand exception |
| stk_exc_o | output | 1 | Stack-underflow exception |
| top_o | output | 3 | Next stack top pointer |
| tag_valid_o | output | 8 | Next per-slot occupancy |

## Verification
The bench builds the unit at its default parameters: a 15-bit exponent, a 64-bit significand and an eight-slot stack. With these values every format class can be built directly, including the pseudo-denormal and unnormal encodings. The three-bit pointer wraps after only eight pops, so the top = 7 boundary and empty-slot underflow come up often in random traffic. Random operands are drawn class by class, and slot i is often a copy of slot 0, with or without its sign flipped, so the equality and signed-zero paths are exercised often.

// File: rtl/xfp_cmp_pkg.sv
package xfp_cmp_pkg;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_UNSUP
    } xfp_class_e;

    typedef enum logic [1:0] {
        REL_GT,
        REL_LT,
        REL_EQ,
        REL_UN
    } xfp_rel_e;

    localparam logic [2:0] FLAGS_GT = 3'b000;
    localparam logic [2:0] FLAGS_LT = 3'b001;
    localparam logic [2:0] FLAGS_EQ = 3'b100;
    localparam logic [2:0] FLAGS_UN = 3'b111;

endpackage

// File: rtl/xfp_classify.sv
module xfp_classify
    import xfp_cmp_pkg::*;
#(
    parameter  int EXP_W = 15,
    parameter  int MAN_W = 64,
    localparam int FMT_W = 1 + EXP_W + MAN_W
) (
    input  logic [FMT_W-1:0] op_i,
    output xfp_class_e       cls_o,
    output logic             sign_o,
    output logic [EXP_W-1:0] eff_exp_o,
    output logic [MAN_W-1:0] mant_o
);

    localparam int QBIT = MAN_W - 2;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             int_bit;
    logic             frac_nz;

    always_comb begin
        exp_f   = op_i[FMT_W-2 -: EXP_W];
        man_f   = op_i[MAN_W-1:0];
        int_bit = man_f[MAN_W-1];
        frac_nz = |man_f[MAN_W-2:0];
        sign_o  = op_i[FMT_W-1];
        mant_o  = man_f;
        // exponent 0 scales like exponent 1 (denormal and pseudo-denormal)
        eff_exp_o = (exp_f == '0) ? EXP_W'(1) : exp_f;

        if (exp_f == '0) begin
            cls_o = (man_f == '0) ? CL_ZERO : CL_DENORM;
        end else if (!int_bit) begin
            cls_o = CL_UNSUP;
        end else if (exp_f == '1) begin
            if (!frac_nz) begin
                cls_o = CL_INF;
            end else if (man_f[QBIT]) begin
                cls_o = CL_QNAN;
            end else begin
                cls_o = CL_SNAN;
            end
        end else begin
            cls_o = CL_NORMAL;
        end
    end

endmodule

// File: rtl/xfp_order.sv
module xfp_order
    import xfp_cmp_pkg::*;
#(
    parameter  int EXP_W = 15,
    parameter  int MAN_W = 64,
    localparam int KEY_W = EXP_W + MAN_W
) (
    input  xfp_class_e       cls_a_i,
    input  logic             sign_a_i,
    input  logic [EXP_W-1:0] exp_a_i,
    input  logic [MAN_W-1:0] mant_a_i,
    input  xfp_class_e       cls_b_i,
    input  logic             sign_b_i,
    input  logic [EXP_W-1:0] exp_b_i,
    input  logic [MAN_W-1:0] mant_b_i,
    output xfp_rel_e         rel_o
);

    logic [KEY_W-1:0] key_a;
    logic [KEY_W-1:0] key_b;
    logic             unord;
    logic             mag_gt;
    logic             a_above;

    always_comb begin
        key_a  = {exp_a_i, mant_a_i};
        key_b  = {exp_b_i, mant_b_i};
        unord  = (cls_a_i inside {CL_QNAN, CL_SNAN, CL_UNSUP}) ||
                 (cls_b_i inside {CL_QNAN, CL_SNAN, CL_UNSUP});
        mag_gt = key_a > key_b;
        a_above = sign_a_i ? !mag_gt : mag_gt;

        if (unord) begin
            rel_o = REL_UN;
        end else if (cls_a_i == CL_ZERO && cls_b_i == CL_ZERO) begin
            rel_o = REL_EQ;
        end else if (sign_a_i != sign_b_i) begin
            rel_o = sign_a_i ? REL_LT : REL_GT;
        end else if (key_a == key_b) begin
            rel_o = REL_EQ;
        end else begin
            rel_o = a_above ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/xfp_stack_step.sv
module xfp_stack_step #(
    parameter  int STACK_DEPTH = 8,
    localparam int PTR_W       = $clog2(STACK_DEPTH)
) (
    input  logic [PTR_W-1:0]       top_i,
    input  logic [STACK_DEPTH-1:0] tag_valid_i,
    input  logic [PTR_W-1:0]       slot_idx_i,
    input  logic                   do_pop_i,
    output logic                   slot0_full_o,
    output logic                   sloti_full_o,
    output logic [PTR_W-1:0]       top_o,
    output logic [STACK_DEPTH-1:0] tag_valid_o
);

    logic [PTR_W-1:0] phys_i;

    assign phys_i       = top_i + slot_idx_i;
    assign slot0_full_o = tag_valid_i[top_i];
    assign sloti_full_o = tag_valid_i[phys_i];
    assign top_o        = do_pop_i ? top_i + PTR_W'(1) : top_i;

    for (genvar s = 0; s < STACK_DEPTH; s++) begin : g_slot
        assign tag_valid_o[s] = tag_valid_i[s] && !(do_pop_i && top_i == PTR_W'(s));
    end

endmodule

// File: rtl/xfp_compare_unit.sv
module xfp_compare_unit
    import xfp_cmp_pkg::*;
#(
    parameter  int EXP_W       = 15,
    parameter  int MAN_W       = 64,
    parameter  int STACK_DEPTH = 8,
    localparam int FMT_W       = 1 + EXP_W + MAN_W,
    localparam int PTR_W       = $clog2(STACK_DEPTH)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cmp_valid_i,
    input  logic                   signal_mode_i,
    input  logic                   pop_req_i,
    input  logic                   inv_mask_i,
    input  logic [FMT_W-1:0]       src0_i,
    input  logic [FMT_W-1:0]       srci_i,
    input  logic [PTR_W-1:0]       slot_idx_i,
    input  logic [PTR_W-1:0]       top_i,
    input  logic [STACK_DEPTH-1:0] tag_valid_i,
    output logic                   done_o,
    output logic                   zf_o,
    output logic                   pf_o,
    output logic                   cf_o,
    output logic                   of_o,
    output logic                   sf_o,
    output logic                   af_o,
    output logic                   c1_o,
    output logic                   inv_exc_o,
    output logic                   stk_exc_o,
    output logic [PTR_W-1:0]       top_o,
    output logic [STACK_DEPTH-1:0] tag_valid_o
);

    typedef struct packed {
        logic                   done;
        logic [2:0]             flags;
        logic [3:0]             misc;
        logic                   inv;
        logic                   stk;
        logic [PTR_W-1:0]       top;
        logic [STACK_DEPTH-1:0] tags;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    xfp_class_e       cls_a, cls_b;
    logic             sign_a, sign_b;
    logic [EXP_W-1:0] exp_a, exp_b;
    logic [MAN_W-1:0] mant_a, mant_b;
    xfp_rel_e         rel;

    logic             slot0_full, sloti_full;
    logic             underflow, any_nan, any_snan, any_unsup;
    logic             invalid, excp, blocked, do_pop;
    logic [PTR_W-1:0]       top_nx;
    logic [STACK_DEPTH-1:0] tags_nx;

    xfp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_a (
        .op_i      (src0_i),
        .cls_o     (cls_a),
        .sign_o    (sign_a),
        .eff_exp_o (exp_a),
        .mant_o    (mant_a)
    );

    xfp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_b (
        .op_i      (srci_i),
        .cls_o     (cls_b),
        .sign_o    (sign_b),
        .eff_exp_o (exp_b),
        .mant_o    (mant_b)
    );

    xfp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_order (
        .cls_a_i  (cls_a),
        .sign_a_i (sign_a),
        .exp_a_i  (exp_a),
        .mant_a_i (mant_a),
        .cls_b_i  (cls_b),
        .sign_b_i (sign_b),
        .exp_b_i  (exp_b),
        .mant_b_i (mant_b),
        .rel_o    (rel)
    );

    // exception decision: underflow takes precedence over operand checks
    always_comb begin
        underflow = !slot0_full || !sloti_full;
        any_nan   = (cls_a inside {CL_QNAN, CL_SNAN}) || (cls_b inside {CL_QNAN, CL_SNAN});
        any_snan  = (cls_a == CL_SNAN) || (cls_b == CL_SNAN);
        any_unsup = (cls_a == CL_UNSUP) || (cls_b == CL_UNSUP);
        invalid   = !underflow && (signal_mode_i ? (any_nan || any_unsup)
                                                 : (any_snan || any_unsup));
        excp      = underflow || invalid;
        blocked   = excp && !inv_mask_i;
        do_pop    = pop_req_i && !blocked;
    end

    xfp_stack_step #(.STACK_DEPTH(STACK_DEPTH)) i_stack (
        .top_i        (top_i),
        .tag_valid_i  (tag_valid_i),
        .slot_idx_i   (slot_idx_i),
        .do_pop_i     (do_pop),
        .slot0_full_o (slot0_full),
        .sloti_full_o (sloti_full),
        .top_o        (top_nx),
        .tag_valid_o  (tags_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = cmp_valid_i;
        st_d.inv  = 1'b0;
        st_d.stk  = 1'b0;
        if (cmp_valid_i) begin
            st_d.misc = '0;
            st_d.inv  = invalid;
            st_d.stk  = underflow;
            st_d.top  = top_nx;
            st_d.tags = tags_nx;
            if (excp) begin
                if (inv_mask_i) begin
                    st_d.flags = FLAGS_UN;
                end
            end else begin
                unique case (rel)
                    REL_GT:  st_d.flags = FLAGS_GT;
                    REL_LT:  st_d.flags = FLAGS_LT;
                    REL_EQ:  st_d.flags = FLAGS_EQ;
                    default: st_d.flags = FLAGS_UN;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign zf_o        = st_q.flags[2];
    assign pf_o        = st_q.flags[1];
    assign cf_o        = st_q.flags[0];
    assign of_o        = st_q.misc[3];
    assign sf_o        = st_q.misc[2];
    assign af_o        = st_q.misc[1];
    assign c1_o        = st_q.misc[0];
    assign inv_exc_o   = st_q.inv;
    assign stk_exc_o   = st_q.stk;
    assign top_o       = st_q.top;
    assign tag_valid_o = st_q.tags;

endmodule

// File: rtl/xfp_compare_chk.sv
module xfp_compare_chk #(
    parameter  int EXP_W       = 15,
    parameter  int MAN_W       = 64,
    parameter  int STACK_DEPTH = 8,
    localparam int PTR_W       = $clog2(STACK_DEPTH)
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   cmp_valid_i,
    input logic                   pop_req_i,
    input logic                   inv_mask_i,
    input logic [PTR_W-1:0]       top_i,
    input logic [STACK_DEPTH-1:0] tag_valid_i,
    input logic                   done_o,
    input logic                   zf_o,
    input logic                   pf_o,
    input logic                   cf_o,
    input logic                   of_o,
    input logic                   sf_o,
    input logic                   af_o,
    input logic                   c1_o,
    input logic                   inv_exc_o,
    input logic                   stk_exc_o,
    input logic [PTR_W-1:0]       top_o,
    input logic [STACK_DEPTH-1:0] tag_valid_o
);

    logic [PTR_W-1:0] top_inc;
    logic [2:0]       flags;

    assign top_inc = top_i + PTR_W'(1);
    assign flags   = {zf_o, pf_o, cf_o};

    assert_flag_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (pf_o == (zf_o && cf_o)));

    assert_masked_unord_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (inv_exc_o || stk_exc_o) && $past(inv_mask_i)) |-> (flags == 3'b111));

    assert_unmasked_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (inv_exc_o || stk_exc_o) && !$past(inv_mask_i)) |-> (flags == $past(flags)));

    assert_misc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !(of_o || sf_o || af_o || c1_o));

    assert_pop_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && pop_req_i && inv_mask_i) |=> (top_o == $past(top_inc)));

    assert_pop_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && pop_req_i && inv_mask_i) |=> !tag_valid_o[$past(top_i)]);

    assert_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_valid_i && !tag_valid_i[top_i]) |=> (stk_exc_o && !inv_exc_o));

    assert_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_valid_i |=> done_o);

    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmp_valid_i |=> (!done_o && $stable(flags) && $stable(top_o) && !inv_exc_o && !stk_exc_o));

endmodule

bind xfp_compare_unit xfp_compare_chk #(
    .EXP_W       (EXP_W),
    .MAN_W       (MAN_W),
    .STACK_DEPTH (STACK_DEPTH)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmp_valid_i (cmp_valid_i),
    .pop_req_i   (pop_req_i),
    .inv_mask_i  (inv_mask_i),
    .top_i       (top_i),
    .tag_valid_i (tag_valid_i),
    .done_o      (done_o),
    .zf_o        (zf_o),
    .pf_o        (pf_o),
    .cf_o        (cf_o),
    .of_o        (of_o),
    .sf_o        (sf_o),
    .af_o        (af_o),
    .c1_o        (c1_o),
    .inv_exc_o   (inv_exc_o),
    .stk_exc_o   (stk_exc_o),
    .top_o       (top_o),
    .tag_valid_o (tag_valid_o)
);

// File: tb/test_xfp_compare_unit.sv
`timescale 1ns/1ps
module test_xfp_compare_unit;

    localparam logic [79:0] ONE   = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
    localparam logic [79:0] TWO   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] NONE  = {1'b1, 15'h3fff, 64'h8000_0000_0000_0000};
    localparam logic [79:0] PZERO = 80'h0;
    localparam logic [79:0] NZERO = {1'b1, 79'h0};
    localparam logic [79:0] QNAN  = {1'b0, 15'h7fff, 64'hC000_0000_0000_0000};
    localparam logic [79:0] SNAN  = {1'b0, 15'h7fff, 64'hA000_0000_0000_0000};
    localparam logic [79:0] UNSUP = {1'b0, 15'h1234, 64'h4000_0000_0000_0000};
    localparam logic [79:0] INF   = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
    localparam logic [79:0] MAXN  = {1'b0, 15'h7ffe, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [79:0] DEN   = {1'b0, 15'h0000, 64'h7FFF_FFFF_FFFF_FFFF};
    localparam logic [79:0] MINN  = {1'b0, 15'h0001, 64'h8000_0000_0000_0000};
    localparam logic [79:0] PDEN  = {1'b0, 15'h0000, 64'h8000_0000_0000_0001};
    localparam logic [79:0] MINN1 = {1'b0, 15'h0001, 64'h8000_0000_0000_0001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, smode = 1'b0, pop = 1'b0, im = 1'b0;
    logic [79:0] a = '0, b = '0;
    logic [2:0]  idx = '0, top = '0;
    logic [7:0]  tags = '0;

    logic        done, zf, pf, cf, of_f, sf_f, af_f, c1;
    logic        inv_e, stk_e;
    logic [2:0]  top_q;
    logic [7:0]  tags_q;

    int n_vec = 0;
    int n_bad = 0;
    logic [2:0] m_flags = 3'b000;

    always #4 clk = ~clk;

    xfp_compare_unit i_xfp_compare_unit (
        .clk_i (clk), .rst_ni (rst_n), .cmp_valid_i (start),
        .signal_mode_i (smode), .pop_req_i (pop), .inv_mask_i (im),
        .src0_i (a), .srci_i (b), .slot_idx_i (idx), .top_i (top),
        .tag_valid_i (tags), .done_o (done), .zf_o (zf), .pf_o (pf),
        .cf_o (cf), .of_o (of_f), .sf_o (sf_f), .af_o (af_f), .c1_o (c1),
        .inv_exc_o (inv_e), .stk_exc_o (stk_e), .top_o (top_q),
        .tag_valid_o (tags_q)
    );

    task automatic check(input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // class codes: 0 zero 1 denormal 2 normal 3 inf 4 qnan 5 snan 6 unsupported
    function automatic int cls_of(input logic [79:0] v);
        logic [14:0] e = v[78:64];
        logic [63:0] m = v[63:0];
        if (e == 15'h0) return (m == 64'h0) ? 0 : 1;
        if (!m[63]) return 6;
        if (e == 15'h7fff) begin
            if (m[62:0] == 63'h0) return 3;
            return m[62] ? 4 : 5;
        end
        return 2;
    endfunction

    // returns the flags code for the ordering of x against y
    function automatic logic [2:0] order_code(input logic [79:0] x, input logic [79:0] y);
        int cx = cls_of(x);
        int cy = cls_of(y);
        logic [78:0] kx, ky;
        logic gt;
        if (cx >= 4 || cy >= 4) return 3'b111;
        if (cx == 0 && cy == 0) return 3'b100;
        if (x[79] != y[79]) return x[79] ? 3'b001 : 3'b000;
        kx = {(x[78:64] == 15'h0) ? 15'h1 : x[78:64], x[63:0]};
        ky = {(y[78:64] == 15'h0) ? 15'h1 : y[78:64], y[63:0]};
        if (kx == ky) return 3'b100;
        gt = (kx > ky) ^ x[79];
        return gt ? 3'b000 : 3'b001;
    endfunction

    task automatic apply(input string req, input logic [79:0] va, input logic [79:0] vb,
                         input logic [2:0] vidx, input logic [2:0] vtop,
                         input logic [7:0] vtags, input logic vmode,
                         input logic vpop, input logic vim);
        logic under, inv, exc, blk;
        int ca, cb;
        logic [2:0] e_top;
        logic [7:0] e_tags;
        @(negedge clk);
        a = va; b = vb; idx = vidx; top = vtop; tags = vtags;
        smode = vmode; pop = vpop; im = vim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ca = cls_of(va);
        cb = cls_of(vb);
        under = !(vtags[vtop] && vtags[3'(vtop + vidx)]);
        inv = !under && (vmode ? (ca >= 4 || cb >= 4) : (ca >= 5 || cb >= 5));
        exc = under || inv;
        blk = exc && !vim;
        if (exc) begin
            if (vim) m_flags = 3'b111;
        end else begin
            m_flags = order_code(va, vb);
        end
        e_top = vtop;
        e_tags = vtags;
        if (vpop && !blk) begin
            e_tags[vtop] = 1'b0;
            e_top = vtop + 3'd1;
        end
        check("R11", "done", 80'(done), 80'(1'b1));
        check(req, "flags", 80'({zf, pf, cf}), 80'(m_flags));
        check("R4 R5", "invalid", 80'(inv_e), 80'(inv));
        check("R9", "underflow", 80'(stk_e), 80'(under));
        check("R7", "of/sf/af/c1", 80'({of_f, sf_f, af_f, c1}), 80'(4'b0));
        check("R8", "top", 80'(top_q), 80'(e_top));
        check("R8", "tags", 80'(tags_q), 80'(e_tags));
        // idle cycle: nothing moves, exceptions drop
        @(negedge clk);
        check("R11", "idle done", 80'(done), 80'(1'b0));
        check("R11", "idle flags", 80'({zf, pf, cf}), 80'(m_flags));
        check("R11", "idle exc", 80'({inv_e, stk_e}), 80'(2'b00));
        check("R11", "idle top", 80'(top_q), 80'(e_top));
    endtask

    function automatic logic [79:0] build_op(input int kind);
        logic        s = 1'($urandom);
        logic [62:0] r = {31'($urandom), 32'($urandom)};
        logic [14:0] e = 15'h3ff0 + 15'($urandom % 32);
        case (kind)
            0: return {s, 79'h0};
            1: return {s, 15'h0, 1'b0, r | 63'h1};
            2: return {s, e, 1'b1, ($urandom % 2 == 0) ? 63'($urandom % 4) : r};
            3: return {s, 15'h7fff, 64'h8000_0000_0000_0000};
            4: return {s, 15'h7fff, 2'b11, r[60:0]};
            5: return {s, 15'h7fff, 2'b10, r[60:0] | 61'h1};
            6: return {s, e, 1'b0, r};
            default: return {s, 15'h0, 1'b1, r};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "reset outputs",
              80'({done, zf, pf, cf, of_f, sf_f, af_f, c1, inv_e, stk_e, top_q, tags_q}), 80'(0));

        apply("R1", ONE, TWO, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R1", TWO, ONE, 3'd1, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b0);
        apply("R1", ONE, ONE, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R1", NONE, ONE, 3'd2, 3'd3, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R3", PZERO, NZERO, 3'd1, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b0);
        apply("R3", NZERO, PZERO, 3'd4, 3'd5, 8'hFF, 1'b0, 1'b0, 1'b1);
        apply("R2 R5", QNAN, ONE, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R4", ONE, QNAN, 3'd1, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b1);
        apply("R1", TWO, ONE, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R6", SNAN, ONE, 3'd1, 3'd2, 8'hFF, 1'b0, 1'b1, 1'b0);
        apply("R5", UNSUP, ONE, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b1);
        apply("R10", INF, MAXN, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R10", DEN, MINN, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R10", PDEN, MINN1, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R10", {1'b1, INF[78:0]}, {1'b1, MAXN[78:0]}, 3'd1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0);
        apply("R8", ONE, TWO, 3'd1, 3'd7, 8'hFF, 1'b0, 1'b1, 1'b1);
        apply("R8", TWO, ONE, 3'd3, 3'd2, 8'hFF, 1'b0, 1'b1, 1'b0);
        apply("R9", ONE, TWO, 3'd2, 3'd1, 8'b1111_0111, 1'b0, 1'b1, 1'b0);
        apply("R9", ONE, TWO, 3'd0, 3'd6, 8'b1011_1111, 1'b0, 1'b1, 1'b1);

        for (int n = 0; n < 3000; n++) begin
            logic [79:0] ra, rb;
            int pick;
            ra = build_op(int'($urandom % 8));
            pick = int'($urandom % 10);
            if (pick < 3) rb = ra;
            else if (pick == 3) rb = {~ra[79], ra[78:0]};
            else rb = build_op(int'($urandom % 8));
            apply("R1", ra, rb, 3'($urandom), 3'($urandom),
                  ($urandom % 5 == 0) ? 8'($urandom) : 8'hFF,
                  1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule